// File: doc/BRIEF.md
# Floating-Point Exception Flags and Trap Enable Unit

This unit keeps the status and control state that a floating-point coprocessor reports after each arithmetic operation. When an operation finishes, the datapath sends a one-cycle completion pulse. The pulse carries an 8-bit exception vector and four flags that classify the result: negative, zero, infinite and not-a-number.

On that pulse the unit does three things. It overwrites the per-operation exception byte. It ORs the vector into a sticky accrued byte. It loads the condition-code nibble. Software fills an exception-enable byte. If a completion carries any exception whose enable bit is set, the unit raises a trap request, and the request holds until software acknowledges it.

Software reaches a 16-bit control word and a 32-bit status word through a plain 32-bit register port. The rounding-mode byte from the control word is also driven out to the datapath.

Top module: `fpu_flag_unit`

## Requirements
- R1: After reset, the control word and the status word both read as zero, `trap_req` is low and `mode_ctrl` is zero.
- R2: With `reg_sel`=0, the register port reaches the control word. The enable byte is at bits 15:8 and the mode byte at bits 7:0. Bits 31:16 read as zero and ignore writes, and `mode_ctrl` follows bits 7:0.
- R3: With `reg_sel`=1 the port reaches the status word. Bits 7:0 are the last-operation exception byte, and each completion overwrites it with `op_exc`. The bit order from 7 down to 0 is: branch-on-unordered, signalling NaN, operand error, overflow, underflow, divide-by-zero, inexact result, inexact decimal input.
- R4: Status bits 15:8 hold the accrued byte. A completion ORs `op_exc` into it, so a bit that is set stays set while only completions arrive.
- R5: Status bits 27:24 hold the condition code. A completion loads N into bit 27, Z into bit 26, infinity into bit 25 and NaN into bit 24. Bits 31:28 read as zero and ignore writes.
- R6: `trap_req` rises in the cycle after a completion whose `op_exc` ANDed with the enable byte is non-zero. It does not rise when that AND is zero.
- R7: `trap_req` stays high until a cycle with `trap_ack` high. It falls one cycle after that, unless a trapping completion arrives in the same cycle as the acknowledge, in which case it stays high.
- R8: A software write to the status word in the same cycle as a completion takes priority. The status word then holds the written value, and the completion leaves no mark on any status field.
- R9: Writing zero to status bits 15:8 clears the accrued byte. Exceptions raised before the clear no longer appear there.
- R10: Status bits 23:16 are a quotient byte. It keeps the value software wrote and is not changed by completions.
- R11: Clearing an enable bit disarms that exception. A later completion that raises only disabled exceptions leaves `trap_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done | input | 1 | One-cycle completion pulse from the datapath |
| op_exc | input | 8 | Exceptions raised by the finishing operation |
| op_neg | input | 1 | Result is negative |
| op_zero | input | 1 | Result is zero |
| op_inf | input | 1 | Result is infinite |
| op_nan | input | 1 | Result is not-a-number |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the status word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected word (combinational) |
| trap_ack | input | 1 | Software acknowledge of a pending trap |
| trap_req | output | 1 | Trap request to the processor |
| mode_ctrl | output | 8 | Rounding mode and precision byte for the datapath |

## Verification
Each completion rewrites three status fields and may set the trap. A corrupted enable byte or accrued byte therefore shows up on `reg_rdata` or `trap_req` one clock after the next completion. The accrued byte is checked as a running OR over a sequence of completions, so a lost bit is caught even when it was set several operations earlier. The write-versus-completion collision, the acknowledge-versus-new-trap collision and the bits that read as zero are driven one at a time, and each is read back in the cycle after its effect.

// File: rtl/fpu_flag_unit.sv
module fpu_flag_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_done,
  input  logic [7:0]  op_exc,
  input  logic        op_neg,
  input  logic        op_zero,
  input  logic        op_inf,
  input  logic        op_nan,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        trap_ack,
  output logic        trap_req,
  output logic [7:0]  mode_ctrl
);

  logic [7:0] en_q, mode_q, exc_q, acc_q, quo_q;
  logic [3:0] cc_q;
  logic       ctl_wr, sts_wr, trap_hit;

  assign ctl_wr   = reg_wr & ~reg_sel;
  assign sts_wr   = reg_wr &  reg_sel;
  assign trap_hit = op_done & (|(op_exc & en_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 8'h00;
      mode_q <= 8'h00;
    end else if (ctl_wr) begin
      en_q   <= reg_wdata[15:8];
      mode_q <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_q  <= 4'h0;
      quo_q <= 8'h00;
      acc_q <= 8'h00;
      exc_q <= 8'h00;
    end else if (sts_wr) begin
      cc_q  <= reg_wdata[27:24];
      quo_q <= reg_wdata[23:16];
      acc_q <= reg_wdata[15:8];
      exc_q <= reg_wdata[7:0];
    end else if (op_done) begin
      cc_q  <= {op_neg, op_zero, op_inf, op_nan};
      acc_q <= acc_q | op_exc;
      exc_q <= op_exc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        trap_req <= 1'b0;
    else if (trap_hit) trap_req <= 1'b1;
    else if (trap_ack) trap_req <= 1'b0;
  end

  assign reg_rdata = reg_sel ? {4'h0, cc_q, quo_q, acc_q, exc_q}
                             : {16'h0000, en_q, mode_q};
  assign mode_ctrl = mode_q;

endmodule

// File: rtl/fpu_flag_unit_chk.sv
module fpu_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_done,
  input logic [7:0]  op_exc,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        trap_ack,
  input logic        trap_req,
  input logic [7:0]  en_q,
  input logic [7:0]  exc_q,
  input logic [7:0]  acc_q
);

  assert_ctl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> reg_rdata[31:16] == 16'h0000);

  assert_exc_latest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !(reg_wr && reg_sel)) |=> exc_q == $past(op_exc));

  assert_acc_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel) |=> (acc_q & $past(acc_q)) == $past(acc_q));

  assert_trap_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && (|(op_exc & en_q))) |=> trap_req);

  assert_trap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_done && !trap_req) |=> !trap_req);

  assert_trap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !trap_ack) |=> trap_req);

  assert_sw_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> (exc_q == $past(reg_wdata[7:0]) && acc_q == $past(reg_wdata[15:8])));

endmodule

bind fpu_flag_unit fpu_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_exc(op_exc),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .trap_ack(trap_ack), .trap_req(trap_req),
  .en_q(en_q), .exc_q(exc_q), .acc_q(acc_q)
);

// File: tb/fpu_flag_unit_test.sv
module fpu_flag_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {enable[27:20], exc[19:12], flags NZIQ[11:8], expected trap[0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {8'h00, 8'h80, 4'h8, 8'h00},
    {8'h01, 8'h01, 4'h4, 8'h01},
    {8'hF0, 8'h0F, 4'h2, 8'h00},
    {8'h10, 8'h12, 4'h1, 8'h01},
    {8'hFF, 8'h00, 4'h0, 8'h00},
    {8'h24, 8'h24, 4'hA, 8'h01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_done = 1'b0, op_neg = 1'b0, op_zero = 1'b0, op_inf = 1'b0, op_nan = 1'b0;
  logic [7:0] op_exc = 8'h00;
  logic reg_wr = 1'b0, reg_sel = 1'b0, trap_ack = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic trap_req;
  logic [7:0] mode_ctrl;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] acc_model;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_exc(op_exc),
    .op_neg(op_neg), .op_zero(op_zero), .op_inf(op_inf), .op_nan(op_nan),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trap_ack(trap_ack), .trap_req(trap_req),
    .mode_ctrl(mode_ctrl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic complete(input logic [7:0] e, input logic [3:0] f);
    op_done = 1'b1; op_exc = e; {op_neg, op_zero, op_inf, op_nan} = f;
    @(negedge clk);
    op_done = 1'b0; op_exc = 8'h00;
  endtask

  task automatic rd(input logic sel);
    reg_sel = sel; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0); check("R1 ctrl", reg_rdata, 32'h0);
    rd(1'b1); check("R1 status", reg_rdata, 32'h0);
    check("R1 trap", {31'h0, trap_req}, 32'h0);
    check("R1 mode", {24'h0, mode_ctrl}, 32'h0);

    acc_model = 8'h00;
    for (int i = 0; i < NVEC; i++) begin
      wr(1'b0, {16'h0, VEC[i][27:20], 8'h00});
      complete(VEC[i][19:12], VEC[i][11:8]);
      acc_model = acc_model | VEC[i][19:12];
      rd(1'b1);
      check("R3 exc byte", {24'h0, reg_rdata[7:0]}, {24'h0, VEC[i][19:12]});
      check("R4 accrued", {24'h0, reg_rdata[15:8]}, {24'h0, acc_model});
      check("R5 cc", {28'h0, reg_rdata[27:24]}, {28'h0, VEC[i][11:8]});
      check("R6 trap", {31'h0, trap_req}, {31'h0, VEC[i][0]});
      trap_ack = 1'b1; @(negedge clk); trap_ack = 1'b0;
      check("R7 ack clears", {31'h0, trap_req}, 32'h0);
    end

    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0); check("R2 ctrl upper zero", reg_rdata, 32'h0000_FFFF);
    check("R2 mode out", {24'h0, mode_ctrl}, 32'h0000_00FF);
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1); check("R5 cc upper zero", reg_rdata, 32'h0FFF_FFFF);

    wr(1'b1, 32'h005A_0000);
    complete(8'h40, 4'h8);
    check("R10 quotient kept", reg_rdata, 32'h085A_4040);
    check("R6 trap", {31'h0, trap_req}, 32'h1);
    repeat (3) @(negedge clk);
    check("R7 hold", {31'h0, trap_req}, 32'h1);
    trap_ack = 1'b1; op_done = 1'b1; op_exc = 8'h02;
    @(negedge clk);
    trap_ack = 1'b0; op_done = 1'b0; op_exc = 8'h00;
    check("R7 new trap beats ack", {31'h0, trap_req}, 32'h1);
    trap_ack = 1'b1; @(negedge clk); trap_ack = 1'b0;
    check("R7 cleared", {31'h0, trap_req}, 32'h0);

    wr(1'b1, 32'h0000_0000);
    check("R9 accrued cleared", reg_rdata, 32'h0);
    complete(8'h04, 4'h0);
    check("R9 accrued after clear", {24'h0, reg_rdata[15:8]}, 32'h04);

    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0311_2233;
    op_done = 1'b1; op_exc = 8'hC0; {op_neg, op_zero, op_inf, op_nan} = 4'hF;
    @(negedge clk);
    reg_wr = 1'b0; op_done = 1'b0; op_exc = 8'h00;
    check("R8 sw write wins", reg_rdata, 32'h0311_2233);
    trap_ack = 1'b1; @(negedge clk); trap_ack = 1'b0;

    wr(1'b0, 32'h0000_0800);
    wr(1'b0, 32'h0000_0000);
    complete(8'h08, 4'h0);
    check("R11 disarmed", {31'h0, trap_req}, 32'h0);

    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd(1'b1); check("R1 status after reset", reg_rdata, 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule